// File: doc/BRIEF.md
# Supply and Thermal Fault Supervisor

This block watches two digitised measurements, a supply-voltage code and a junction-temperature code, and decides whether a gate driver may fire its power device. It keeps the driver locked out while the supply is low, raises a warning when the die gets hot, and forces the output off when the die gets too hot. Each of the three conditions has its own hysteresis band, so a trip point and its release point differ and ripple on a measurement cannot make a flag toggle.

Its outputs go straight to a turn-on sequencer. `drv_en_o` permits firing. `alarm_n_o` is an active-low warning that also reflects an external overload fault. All thresholds and bands are set by parameters. The analog sensing and the conversion to codes happen outside the block.

Top module: `supply_thermal_sup`

## Requirements
- R1: After reset (synchronous, active high), and on the first clock edge after reset falls, the block is in lockout with both thermal flags clear: `drv_en_o`=0, `uvlo_o`=1, `ot_warn_o`=0, `ot_shdn_o`=0, `alarm_n_o`=1 when `ovl_fault_i`=0.
- R2: While in lockout, `uvlo_o` clears one clock after `vsup_i` (unsigned) is sampled at or above UV_HI. Codes below UV_HI keep lockout asserted.
- R3: Once lockout is clear, it re-engages one clock after `vsup_i` is sampled strictly below UV_HI-UV_HYS. Codes from UV_HI-UV_HYS upward keep it clear.
- R4: `ot_warn_o` sets one clock after `temp_i` (signed, whole degrees Celsius) is sampled at or above WARN_T (default 130). It clears only one clock after `temp_i` is sampled strictly below WARN_T-T_HYS (default 110).
- R5: `ot_shdn_o` sets one clock after `temp_i` is sampled at or above SHDN_T (default 160). It stays set until `temp_i` is sampled strictly below SHDN_T-T_HYS (default 140).
- R6: `drv_en_o` is 1 exactly when both `uvlo_o` and `ot_shdn_o` are 0. It changes on the same clock edge as those flags.
- R7: `alarm_n_o` is 0 exactly when `ot_warn_o` is 1 or the registered `ovl_fault_i` is 1. It changes on the same clock edge as `ot_warn_o`, and one clock after the sample of `ovl_fault_i`.
- R8: Negative temperature codes are compared as signed values and never set a thermal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsup_i | input | VW (10) | Unsigned supply code |
| temp_i | input | TW (9) | Signed temperature code, degrees C |
| ovl_fault_i | input | 1 | External overload fault |
| drv_en_o | output | 1 | Permission to fire the power device |
| uvlo_o | output | 1 | Under-voltage lockout active |
| ot_warn_o | output | 1 | Over-temperature warning active |
| ot_shdn_o | output | 1 | Over-temperature shutdown active |
| alarm_n_o | output | 1 | Active-low alarm |

## Verification
The assertions check every cycle that each flag moves only in the allowed direction. A flag may set only after a sample at or past its trip point, and it may clear only after a sample past its release point. They also check that the enable and the alarm always agree with the registered flags. The bench scenarios must supply the exact boundary codes: one below the trip point, at the trip point, inside the band, at the release point and just below it. They also cover negative temperatures and the interplay where shutdown overrides an otherwise healthy supply. Only these scenarios show that the hysteresis bands are positioned correctly.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {ST_CLEAR = 1'b0, ST_TRIPPED = 1'b1} trip_st_t;
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int W       = 10,
  parameter bit SIGNED  = 1'b0,
  parameter bit LOW_TRIP = 1'b0,
  parameter int TRIP    = 100,
  parameter int HYS     = 10,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] val_i,
  output logic         flag_o
);
  import sup_pkg::*;
  localparam int REL = LOW_TRIP ? TRIP + HYS : TRIP - HYS;

  logic signed [W+1:0] v_ext;
  logic                hit_trip, hit_rel;
  trip_st_t            st_q;

  always_comb begin
    if (SIGNED) v_ext = {{2{val_i[W-1]}}, val_i};
    else        v_ext = {2'b00, val_i};
  end

  generate
    if (LOW_TRIP) begin : g_low
      // trips below REL-HYS (=TRIP), releases at/above REL
      assign hit_trip = v_ext <  (W+2)'(TRIP);
      assign hit_rel  = v_ext >= (W+2)'(REL);
    end else begin : g_high
      assign hit_trip = v_ext >= (W+2)'(TRIP);
      assign hit_rel  = v_ext <  (W+2)'(REL);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) st_q <= trip_st_t'(RST_VAL);
    else if (st_q == ST_CLEAR && hit_trip) st_q <= ST_TRIPPED;
    else if (st_q == ST_TRIPPED && hit_rel) st_q <= ST_CLEAR;
  end

  assign flag_o = (st_q == ST_TRIPPED);

  p_set_needs_trip_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(hit_trip));
  p_clr_needs_rel_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> $past(hit_rel));
endmodule

// File: rtl/supply_thermal_sup.sv
module supply_thermal_sup #(
  parameter int VW     = 10,
  parameter int TW     = 9,
  parameter int UV_HI  = 600,
  parameter int UV_HYS = 50,
  parameter int WARN_T = 130,
  parameter int SHDN_T = 160,
  parameter int T_HYS  = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] vsup_i,
  input  logic [TW-1:0] temp_i,
  input  logic          ovl_fault_i,
  output logic          drv_en_o,
  output logic          uvlo_o,
  output logic          ot_warn_o,
  output logic          ot_shdn_o,
  output logic          alarm_n_o
);
  localparam int UV_LO = UV_HI - UV_HYS;

  logic ok_supply, warn, shdn, ovl_q;

  // ok_supply sets at UV_HI, clears below UV_LO
  hyst_cmp #(.W(VW), .SIGNED(1'b0), .LOW_TRIP(1'b0), .TRIP(UV_HI),
             .HYS(UV_HYS), .RST_VAL(1'b0)) u_uv (
    .clk(clk), .rst(rst), .val_i(vsup_i), .flag_o(ok_supply));

  hyst_cmp #(.W(TW), .SIGNED(1'b1), .LOW_TRIP(1'b0), .TRIP(WARN_T),
             .HYS(T_HYS), .RST_VAL(1'b0)) u_warn (
    .clk(clk), .rst(rst), .val_i(temp_i), .flag_o(warn));

  hyst_cmp #(.W(TW), .SIGNED(1'b1), .LOW_TRIP(1'b0), .TRIP(SHDN_T),
             .HYS(T_HYS), .RST_VAL(1'b0)) u_shdn (
    .clk(clk), .rst(rst), .val_i(temp_i), .flag_o(shdn));

  always_ff @(posedge clk) begin
    if (rst) ovl_q <= 1'b0;
    else     ovl_q <= ovl_fault_i;
  end

  assign uvlo_o    = ~ok_supply;
  assign ot_warn_o = warn;
  assign ot_shdn_o = shdn;
  assign drv_en_o  = ok_supply & ~shdn;
  assign alarm_n_o = ~(warn | ovl_q);

  p_uv_release_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(uvlo_o) |-> $past(vsup_i) >= VW'(UV_HI));
  p_uv_engage_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(uvlo_o) |-> $past(vsup_i) < VW'(UV_LO));
  p_enable_gated_r6: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |-> (!uvlo_o && !ot_shdn_o));
  p_alarm_src_r7: assert property (@(posedge clk) disable iff (rst)
    $past(ovl_fault_i) |-> !alarm_n_o);
  p_neg_no_trip_r8: assert property (@(posedge clk) disable iff (rst)
    $past(temp_i[TW-1]) |-> !$rose(ot_warn_o));
endmodule

// File: tb/test_supply_thermal_sup.sv
`timescale 1ns/1ps
module test_supply_thermal_sup;
  logic clk = 0, rst = 1;
  logic [9:0] vsup = 0;
  logic [8:0] temp = 9'sd25;
  logic ovl = 0;
  logic drv_en, uvlo, warn, shdn, alarm_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  supply_thermal_sup i_supply_thermal_sup (
    .clk(clk), .rst(rst), .vsup_i(vsup), .temp_i(temp), .ovl_fault_i(ovl),
    .drv_en_o(drv_en), .uvlo_o(uvlo), .ot_warn_o(warn), .ot_shdn_o(shdn),
    .alarm_n_o(alarm_n));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive after negedge, one posedge, sample at next negedge
  task automatic step(input int v, input int t);
    @(negedge clk);
    vsup = 10'(v);
    temp = 9'(t);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; vsup = 10'd700; temp = 9'd25; ovl = 0;
    repeat (2) @(negedge clk);
    chk("R1 uvlo", uvlo, 1); chk("R1 drv", drv_en, 0);
    chk("R1 warn", warn, 0); chk("R1 shdn", shdn, 0); chk("R1 alarm", alarm_n, 1);
    vsup = 10'd0;
    rst = 0;
    @(negedge clk);
    chk("R1 still locked", uvlo, 1);
  endtask

  task automatic t_uvlo();
    step(599, 25); chk("R2 below hi", uvlo, 1); chk("R2 drv", drv_en, 0);
    step(600, 25); chk("R2 at hi", uvlo, 0); chk("R6 drv on", drv_en, 1);
    step(550, 25); chk("R3 at lo", uvlo, 0);
    step(549, 25); chk("R3 below lo", uvlo, 1); chk("R6 drv off", drv_en, 0);
    step(580, 25); chk("R2 in band", uvlo, 1);
    step(700, 25); chk("R2 release", uvlo, 0);
  endtask

  task automatic t_thermal();
    step(700, 129); chk("R4 below", warn, 0); chk("R7 alarm", alarm_n, 1);
    step(700, 130); chk("R4 at", warn, 1); chk("R7 alarm low", alarm_n, 0);
    step(700, 110); chk("R4 band", warn, 1);
    step(700, 109); chk("R4 clear", warn, 0); chk("R7 alarm hi", alarm_n, 1);
    step(700, 159); chk("R5 below", shdn, 0); chk("R6 drv", drv_en, 1);
    step(700, 160); chk("R5 at", shdn, 1); chk("R6 shdn drv", drv_en, 0);
    step(700, 140); chk("R5 band", shdn, 1); chk("R6 held", drv_en, 0);
    step(700, 139); chk("R5 clear", shdn, 0); chk("R6 back", drv_en, 1);
    chk("R4 still warn", warn, 1);
    step(700, 100); chk("R4 cool", warn, 0);
  endtask

  task automatic t_neg();
    step(700, -200); chk("R8 warn", warn, 0); chk("R8 shdn", shdn, 0);
    step(700, -1); chk("R8 warn2", warn, 0); chk("R8 drv", drv_en, 1);
  endtask

  task automatic t_ovl();
    @(negedge clk); ovl = 1;
    chk("R7 not yet", alarm_n, 1);
    @(negedge clk); chk("R7 ovl", alarm_n, 0); chk("R7 drv unaffected", drv_en, 1);
    ovl = 0;
    @(negedge clk); chk("R7 ovl clr", alarm_n, 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_uvlo(); t_thermal(); t_neg(); t_ovl();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule